// File: doc/BRIEF.md
# PCI Interrupt Pin Router

This block steers four level-sensitive PCI interrupt pins onto a sixteen-line legacy interrupt request vector. Software picks the destination line of each pin by writing 4-bit selector fields. The fields sit in three configuration bytes at consecutive byte addresses, and they are packed unevenly across those bytes. Pin 0 and pin 3 each use only the upper half of their byte. Pins 1 and 2 share the middle byte.

Each output line is the logical OR of every pin that currently selects it. When several pins share a line, that line stays asserted for as long as any one of them holds it. The output vector is registered. A pin change shows up on the outputs one clock later. A new routing shows up one clock after the write that sets it. A line that loses all of its sources falls at that point.

Top module: `pci_irq_router`

## Requirements
- R1: After reset, bytes 0x55, 0x56 and 0x57 read as 0x00 and `irq_out` is all zero. With that routing every pin selects line 0.
- R2: Pin 0 is routed to the line numbered by bits 7:4 of byte 0x55.
- R3: Pin 1 is routed to the line numbered by bits 3:0 of byte 0x56. Pin 2 is routed to the line numbered by bits 7:4 of byte 0x56.
- R4: Pin 3 is routed to the line numbered by bits 7:4 of byte 0x57. Bits 3:0 of bytes 0x55 and 0x57 have no effect on `irq_out`.
- R5: `irq_out[n]` is the OR of the levels of all pins whose selector equals n. When one pin of a shared line falls, the line stays high while another pin routed to it is still high.
- R6: Inputs and outputs are active-high. `irq_out` changes at the first rising edge after a pin level changes. It keeps its old value before that edge.
- R7: After a write to a routing byte at clock edge k, `irq_out` keeps the old routing until edge k+1 and follows the new routing from edge k+1 onward. A line left with no high source deasserts at edge k+1.
- R8: `cfg_rdata` is a combinational read of the byte at `cfg_addr`. Bytes 0x55 to 0x57 return exactly the last value written, including the unused nibbles. Any other address reads 0x00. Writes to any other address change neither the readback nor the routing.
- R9: At most four bits of `irq_out` are high at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_addr | input | 8 | Byte address for configuration read and write |
| cfg_wdata | input | 8 | Write data |
| cfg_we | input | 1 | Write enable, one byte per asserted cycle |
| cfg_rdata | output | 8 | Read data for `cfg_addr` |
| pin_level | input | 4 | PCI interrupt pin levels, bit i is pin i |
| irq_out | output | 16 | Registered interrupt request lines |

## Verification
The hardest situation to reach from the ports is a merged line that loses one of its two sources. The line must stay high only because a second pin still holds it. The same holds when a reprogramming write moves one contributor away while the other remains. The stimulus first routes two or three pins to one line through different byte and nibble positions, including the shared middle byte. It then lowers or re-routes them one at a time and samples after each step. A sweep then walks every pin over all sixteen targets. A pseudo-random pass covers many routing bytes, including nonzero unused nibbles, against all sixteen pin patterns.

// File: rtl/pir_pkg.sv
package pir_pkg;
  localparam int NUM_PINS  = 4;
  localparam int SEL_W     = 4;
  localparam int NUM_LINES = 1 << SEL_W;
  localparam int BYTE_W    = 8;
  localparam int NUM_BYTES = 3;

  typedef logic [SEL_W-1:0]  line_sel_t;
  typedef logic [BYTE_W-1:0] cfg_byte_t;

  // Selector of one pin, picked out of the three routing bytes.
  function automatic line_sel_t pin_target(input cfg_byte_t b_lo,
                                           input cfg_byte_t b_mid,
                                           input cfg_byte_t b_hi,
                                           input int unsigned pin);
    line_sel_t s;
    case (pin)
      0:       s = b_lo[7:4];
      1:       s = b_mid[3:0];
      2:       s = b_mid[7:4];
      default: s = b_hi[7:4];
    endcase
    return s;
  endfunction

  // One-hot mask of a line number.
  function automatic logic [NUM_LINES-1:0] line_mask(input line_sel_t s);
    return {{(NUM_LINES-1){1'b0}}, 1'b1} << s;
  endfunction
endpackage

// File: rtl/pir_cfg_file.sv
module pir_cfg_file
  import pir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h55
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ADDR_W-1:0]             addr,
  input  cfg_byte_t                     wdata,
  input  logic                          we,
  output cfg_byte_t                     rdata,
  output logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_q
);
  logic [NUM_BYTES-1:0] hit_w;   // address decode per byte
  logic [NUM_BYTES-1:0] wr_hit;  // write strobe per byte

  for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
    assign hit_w[i]  = (addr == BASE_ADDR + ADDR_W'(i));
    assign wr_hit[i] = we && hit_w[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         bytes_q[i] <= '0;
      else if (wr_hit[i]) bytes_q[i] <= wdata;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit[i] |=> bytes_q[i] == $past(wdata)); // R8
    AST_HOLD_UNWRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit[i] |=> $stable(bytes_q[i])); // R8
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_BYTES; i++)
      if (hit_w[i]) rdata = bytes_q[i];
  end
endmodule

// File: rtl/pir_or_matrix.sv
module pir_or_matrix
  import pir_pkg::*;
(
  input  logic [NUM_PINS-1:0]              pins,
  input  logic [NUM_PINS-1:0][SEL_W-1:0]   tgt,
  output logic [NUM_LINES-1:0]             line_next
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    always_comb begin
      line_next[n] = 1'b0;
      for (int p = 0; p < NUM_PINS; p++)
        if (tgt[p] == SEL_W'(n)) line_next[n] = line_next[n] | pins[p];
    end
  end
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import pir_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h55
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [BYTE_W-1:0]    cfg_wdata,
  input  logic                 cfg_we,
  output logic [BYTE_W-1:0]    cfg_rdata,
  input  logic [NUM_PINS-1:0]  pin_level,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_BYTES-1:0][BYTE_W-1:0] cfg_bytes;
  logic [NUM_PINS-1:0][SEL_W-1:0]   pin_tgt;
  logic [NUM_LINES-1:0]             line_next;

  pir_cfg_file #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_cfg (
    .clk(clk), .rst_n(rst_n), .addr(cfg_addr), .wdata(cfg_wdata),
    .we(cfg_we), .rdata(cfg_rdata), .bytes_q(cfg_bytes)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_tgt
    assign pin_tgt[p] = pin_target(cfg_bytes[0], cfg_bytes[1], cfg_bytes[2], p);
  end

  pir_or_matrix u_mx (.pins(pin_level), .tgt(pin_tgt), .line_next(line_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= '0;
    else        irq_out <= line_next;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    AST_PIN_REACHES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      pin_level[p] |-> (line_next & line_mask(pin_tgt[p])) != '0); // R5
  end

  AST_QUIET_PINS_QUIET_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pin_level) == '0) |-> irq_out == '0); // R6
  AST_AT_MOST_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= NUM_PINS); // R9
  AST_LINES_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_out == $past(line_next)); // R7
endmodule

// File: tb/pci_irq_router_test.sv
module pci_irq_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_rdata;
  logic [3:0]  pin_level = '0;
  logic [15:0] irq_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Bench copy of the three routing bytes.
  logic [7:0] m55 = 0, m56 = 0, m57 = 0;

  always #5 clk = ~clk;

  pci_irq_router uut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .pin_level(pin_level), .irq_out(irq_out)
  );

  // Expected lines: selector bit offsets inside the word {m57,m56,m55}.
  function automatic logic [15:0] model(input logic [3:0] pins);
    logic [23:0] w = {m57, m56, m55};
    int pos [4] = '{4, 8, 12, 20};
    logic [15:0] r = 0;
    for (int n = 0; n < 16; n++)
      for (int p = 0; p < 4; p++)
        if (pins[p] && ((w >> pos[p]) & 24'hF) == n) r[n] = 1'b1;
    return r;
  endfunction

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    if (a == 8'h55) m55 = d;
    if (a == 8'h56) m56 = d;
    if (a == 8'h57) m57 = d;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    cfg_addr = a; #1;
    chk({8'h0, cfg_rdata}, {8'h0, exp}, req);
  endtask

  task automatic pins_set(input logic [3:0] v);
    @(negedge clk); pin_level = v;
    @(negedge clk);
  endtask

  task automatic route(input logic [3:0] t0, t1, t2, t3, input logic [3:0] junk);
    wr(8'h55, {t0, junk});
    wr(8'h56, {t2, t1});
    wr(8'h57, {t3, ~junk});
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed = 32'h1234_5677;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(irq_out, 16'h0, "R1 irq after reset");
    rd_chk(8'h55, 8'h00, "R1 read 0x55");
    rd_chk(8'h56, 8'h00, "R1 read 0x56");
    rd_chk(8'h57, 8'h00, "R1 read 0x57");
    rst_n = 1'b1;
    pins_set(4'b1000);
    chk(irq_out, 16'h0001, "R1 default route to line 0");
    pins_set(4'b0000);

    // R2/R3/R4: each pin alone over every target
    for (int p = 0; p < 4; p++)
      for (int t = 0; t < 16; t++) begin
        logic [3:0] ts [4] = '{4'd0, 4'd0, 4'd0, 4'd0};
        ts[p] = t[3:0];
        route(ts[0], ts[1], ts[2], ts[3], 4'(t + p));
        pins_set(4'(1 << p));
        chk(irq_out, 16'(1 << t), p == 0 ? "R2 pin0 sweep" :
                                   p == 3 ? "R4 pin3 sweep" : "R3 pin1/2 sweep");
        pins_set(4'b0000);
      end

    // R4: unused nibbles have no effect
    route(4'd3, 4'd5, 4'd7, 4'd9, 4'h0);
    pins_set(4'b1111);
    chk(irq_out, 16'h02A8, "R4 junk nibbles zero");
    wr(8'h55, 8'h3F); wr(8'h57, 8'h9A); @(negedge clk);
    chk(irq_out, 16'h02A8, "R4 junk nibbles set");

    // R8: readback and foreign addresses
    rd_chk(8'h55, 8'h3F, "R8 read 0x55");
    rd_chk(8'h56, 8'h75, "R8 read 0x56");
    rd_chk(8'h57, 8'h9A, "R8 read 0x57");
    wr(8'h54, 8'hFF); wr(8'h58, 8'hFF); @(negedge clk);
    rd_chk(8'h54, 8'h00, "R8 foreign read 0x54");
    rd_chk(8'h58, 8'h00, "R8 foreign read 0x58");
    rd_chk(8'h55, 8'h3F, "R8 0x55 untouched");
    chk(irq_out, 16'h02A8, "R8 routing untouched");

    // R5: merge and partial release
    route(4'd6, 4'd6, 4'd6, 4'd1, 4'h5);
    pins_set(4'b0111);
    chk(irq_out, 16'h0040, "R5 three pins merged");
    pins_set(4'b0110);
    chk(irq_out, 16'h0040, "R5 line held by pin1/2");
    pins_set(4'b0100);
    chk(irq_out, 16'h0040, "R5 line held by pin2");
    pins_set(4'b1000);
    chk(irq_out, 16'h0002, "R5 merged line released");

    // R6: latency of one edge
    @(negedge clk); pin_level = 4'b0001; #1;
    chk(irq_out, 16'h0002, "R6 before edge");
    @(negedge clk);
    chk(irq_out, 16'h0040, "R6 after edge");

    // R7: reprogramming with pin0 high; line 6 loses its only source
    @(negedge clk);
    cfg_addr = 8'h55; cfg_wdata = 8'hC0; cfg_we = 1'b1; m55 = 8'hC0;
    @(negedge clk); cfg_we = 1'b0;
    chk(irq_out, 16'h0040, "R7 old routing after write edge");
    @(negedge clk);
    chk(irq_out, 16'h1000, "R7 new routing, old line dropped");
    // R7: move one contributor away from a shared line
    route(4'd2, 4'd2, 4'd0, 4'd0, 4'h0);
    pins_set(4'b0011);
    chk(irq_out, 16'h0004, "R7 shared line");
    wr(8'h56, 8'h0E); @(negedge clk);
    chk(irq_out, 16'h4004, "R7 line kept by pin0 after move");

    // R5/R9: pseudo-random routings against all pin patterns
    for (int k = 0; k < 60; k++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      wr(8'h55, seed[31:24]); wr(8'h56, seed[23:16]); wr(8'h57, seed[15:8]);
      for (int v = 0; v < 16; v++) begin
        pins_set(4'(v));
        chk(irq_out, model(4'(v)), "R5 random routing");
        if ($countones(irq_out) > 4) chk(irq_out, 16'h0, "R9 too many lines");
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule